// File: doc/BRIEF.md
# DMA Request Burst Pacer

This block drives the request line of a slave-side DMA channel that moves bytes or words between an external DMA controller and an on-chip FIFO. When a transfer starts, it latches a 3-bit burst code, a transfer count, a counter-disable bit, a master/slave select and the direction. It then raises `dreq` either continuously or in fixed-size groups. Each cycle in which `ack` is high while `dreq` is high counts as one transfer. That transfer steps a group counter and, when enabled, a down-counting transfer counter. The remaining count appears on `remaining`, and `done` rises when the counter runs out.

The `dreq`/`ack` pair works as a request/grant handshake. `dreq` is the offer and `ack` is the taker's acceptance. A transfer happens only in a cycle where both are high, and an `ack` while `dreq` is low has no effect. The block applies back-pressure in two ways. A FIFO that cannot take part (full when receiving, empty when sending) drops `dreq` in the same cycle. In grouped modes, a group is not offered unless the FIFO reports, on `fifo_avail`, room or data for all of it.

Top module: `dreq_pacer`

## Requirements
- R1: A synchronous active-high `rst` clears `dreq`, `done` and `remaining` to 0 on the next clock edge.
- R2: Burst code 0 holds `dreq` high with no gap until the final transfer completes, or until the FIFO blocks.
- R3: In slave mode, burst codes 1 through 7 select group sizes of 1, 2, 4, 8, 12, 16 and 32 transfers. `dreq` drops after each complete group and stays low for at least one clock before the next group.
- R4: In a grouped mode, `dreq` is raised for a group only when `fifo_avail` is at least the group size. When the counter is enabled and the remaining count is smaller than the group size, the threshold is the remaining count instead.
- R5: With the counter enabled, each transfer (`ack` high while `dreq` is high) decrements `remaining` by one. When it reaches 0, `dreq` drops and `done` goes high on the same edge. Starting with a count of 0 sets `done` at once and never raises `dreq`.
- R6: In slave mode with `cnt_disable`=1, `remaining` holds the loaded value, and the transfer never ends on the count.
- R7: With `master_mode`=1, the counter is always enabled whatever `cnt_disable` says, and the burst code is ignored: pacing is continuous as for code 0.
- R8: The FIFO blocks when `fifo_full`=1 with `dir_rx`=1, or when `fifo_empty`=1 with `dir_rx`=0. A block drops `dreq` in the same cycle. When the block clears, requesting resumes with the group counter cleared, so the next run is a full group.
- R9: `start` is taken only while no transfer is active. The inputs `burst_code`, `xfer_count`, `cnt_disable`, `master_mode` and `dir_rx` are sampled only when a start is taken; changes while active have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| burst_code | input | 3 | Pacing code: 0 continuous, 1..7 grouped |
| xfer_count | input | CW | Number of transfers to perform |
| cnt_disable | input | 1 | 1 turns the transfer counter off (slave mode only) |
| master_mode | input | 1 | 1 selects master mode |
| dir_rx | input | 1 | 1 means the FIFO is filled (receive), 0 means it is drained |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_avail | input | AW | Free entries (receive) or stored entries (transmit) |
| ack | input | 1 | Transfer acknowledge, one per transfer |
| dreq | output | 1 | DMA request |
| done | output | 1 | Transfer counter reached zero |
| remaining | output | CW | Transfers still to do |

## Verification
The bench targets the grouped sizes, especially the non-power-of-two group of 12. A design that decodes that code wrongly produces runs of the wrong length or the wrong number of bursts. It checks that a FIFO block followed by a resume yields a full-length group; a design that keeps the partial group count would give a short run. It sets `fifo_avail` just below a group and checks that no request is raised, and also checks that a remainder smaller than the group still starts. A design that ignored either rule would request early or stall forever. It toggles the counter disable in both modes and rewrites the inputs during an active transfer. A design that honoured the disable in master mode would never finish, and one that resampled the inputs mid-transfer would change the pacing.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_REQ  = 2'd2,
    ST_GAP  = 2'd3
  } pace_st_t;

  localparam int GW = 6;

  // Group length per burst code; 0 means continuous pacing.
  function automatic logic [GW-1:0] group_size(input logic [2:0] code);
    logic [GW-1:0] s;
    case (code)
      3'd1:    s = GW'(1);
      3'd2:    s = GW'(2);
      3'd3:    s = GW'(4);
      3'd4:    s = GW'(8);
      3'd5:    s = GW'(12);
      3'd6:    s = GW'(16);
      3'd7:    s = GW'(32);
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dreq_group_ctr.sv
module dreq_group_ctr #(
  parameter int GW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          inc,
  input  logic [GW-1:0] size,
  output logic          grp_end
);

  logic [GW-1:0] cnt;

  assign grp_end = inc && (size != '0) && (cnt == size - GW'(1));

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (inc) begin
      if (grp_end)     cnt <= '0;
      else             cnt <= cnt + GW'(1);
    end
  end

  // R3: a group never counts past its size
  a_r3_group_bound: assert property (@(posedge clk) disable iff (rst)
    (inc && size != '0) |-> (cnt < size));

endmodule

// File: rtl/dreq_xfer_ctr.sv
module dreq_xfer_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          cnt_on_in,
  input  logic          dec,
  output logic [CW-1:0] rem,
  output logic          last,
  output logic          cnt_on
);

  assign last = cnt_on && (rem == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      cnt_on <= 1'b0;
    end else if (load) begin
      rem    <= load_val;
      cnt_on <= cnt_on_in;
    end else if (dec && cnt_on && rem != '0) begin
      rem    <= rem - CW'(1);
    end
  end

  // R5: each counted transfer takes exactly one off the count
  a_r5_dec_step: assert property (@(posedge clk) disable iff (rst)
    (dec && cnt_on && rem != '0 && !load) |=> (rem == $past(rem) - CW'(1)));

  // R6: a switched-off counter keeps its value
  a_r6_hold_off: assert property (@(posedge clk) disable iff (rst)
    (!cnt_on && !load) |=> $stable(rem));

endmodule

// File: rtl/dreq_pacer.sv
module dreq_pacer
  import dreq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    burst_code,
  input  logic [CW-1:0] xfer_count,
  input  logic          cnt_disable,
  input  logic          master_mode,
  input  logic          dir_rx,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  input  logic [AW-1:0] fifo_avail,
  input  logic          ack,
  output logic          dreq,
  output logic          done,
  output logic [CW-1:0] remaining
);

  localparam int MW = (CW > AW) ? CW : AW;

  pace_st_t      st;
  logic [2:0]    code_q;
  logic          dir_q;
  logic          done_q;
  logic          cnt_on;
  logic          last;
  logic          grp_end;
  logic [CW-1:0] rem;

  logic          take_start;
  logic          cnt_on_in;
  logic          zero_start;
  logic          blocked;
  logic          in_req;
  logic          fire;
  logic [GW-1:0] gsize;
  logic [CW-1:0] gs_ext;
  logic [CW-1:0] need;
  logic          eligible;
  logic          grp_clear;

  assign take_start = (st == ST_IDLE) && start;
  assign cnt_on_in  = master_mode || !cnt_disable;
  assign zero_start = cnt_on_in && (xfer_count == '0);

  assign blocked = dir_q ? fifo_full : fifo_empty;
  assign in_req  = (st == ST_REQ);
  assign dreq    = in_req && !blocked;
  assign fire    = dreq && ack;

  assign gsize  = group_size(code_q);
  assign gs_ext = CW'(gsize);
  assign need   = (cnt_on && rem < gs_ext) ? rem : gs_ext;

  always_comb begin
    if (blocked)              eligible = 1'b0;
    else if (code_q == 3'd0)  eligible = 1'b1;
    else                      eligible = MW'(fifo_avail) >= MW'(need);
  end

  assign grp_clear = take_start || (in_req && blocked);

  dreq_xfer_ctr #(.CW(CW)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .load      (take_start),
    .load_val  (xfer_count),
    .cnt_on_in (cnt_on_in),
    .dec       (fire),
    .rem       (rem),
    .last      (last),
    .cnt_on    (cnt_on)
  );

  dreq_group_ctr #(.GW(GW)) u_grp (
    .clk     (clk),
    .rst     (rst),
    .clear   (grp_clear),
    .inc     (fire),
    .size    (gsize),
    .grp_end (grp_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      code_q <= 3'd0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            code_q <= master_mode ? 3'd0 : burst_code;
            dir_q  <= dir_rx;
            if (zero_start) begin
              done_q <= 1'b1;
            end else begin
              done_q <= 1'b0;
              st     <= ST_ARM;
            end
          end
        end
        ST_ARM: begin
          if (eligible) st <= ST_REQ;
        end
        ST_REQ: begin
          if (fire) begin
            if (last) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else if (grp_end) begin
              st <= ST_GAP;
            end
          end else if (blocked) begin
            st <= ST_ARM;
          end
        end
        default: st <= ST_ARM;
      endcase
    end
  end

  assign done      = done_q;
  assign remaining = rem;

  // R3: the clock after a completed group has no request
  a_r3_gap_low: assert property (@(posedge clk) disable iff (rst)
    (fire && grp_end && !last) |=> !dreq);

  // R5: the final transfer ends the request and flags completion
  a_r5_done_drop: assert property (@(posedge clk) disable iff (rst)
    (fire && last) |=> (done && !dreq && remaining == '0));

  // R8: a blocked FIFO sends the pacer back to re-arm
  a_r8_block_rearm: assert property (@(posedge clk) disable iff (rst)
    (in_req && blocked) |=> (st == ST_ARM));

  // R9: latched pacing stays fixed while a transfer runs
  a_r9_code_stable: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> ($stable(code_q) && $stable(dir_q)));

  // R4: a group request only starts when the FIFO can cover it
  a_r4_arm_gate: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARM && code_q != 3'd0 && MW'(fifo_avail) < MW'(need)) |=> (st != ST_REQ));

endmodule

// File: tb/sim_dreq_pacer.sv
module sim_dreq_pacer;

  localparam int CW = 16;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    burst_code = '0;
  logic [CW-1:0] xfer_count = '0;
  logic          cnt_disable = 1'b0;
  logic          master_mode = 1'b0;
  logic          dir_rx = 1'b0;
  logic          fifo_full = 1'b0;
  logic          fifo_empty = 1'b0;
  logic [AW-1:0] fifo_avail = AW'(64);
  logic          ack_en = 1'b0;
  logic          ack;
  logic          dreq;
  logic          done;
  logic [CW-1:0] remaining;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  assign ack = ack_en & dreq;

  always #2 clk = ~clk;

  dreq_pacer #(.CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .start(start), .burst_code(burst_code),
    .xfer_count(xfer_count), .cnt_disable(cnt_disable), .master_mode(master_mode),
    .dir_rx(dir_rx), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_avail(fifo_avail), .ack(ack), .dreq(dreq), .done(done),
    .remaining(remaining)
  );

  // Vector layout: code nibble, master nibble, count byte, bursts byte, longest run byte
  localparam logic [31:0] VEC [9] = '{
    32'h1_0_05_05_01,
    32'h2_0_05_03_02,
    32'h3_0_08_02_04,
    32'h4_0_14_03_08,
    32'h5_0_19_03_0C,
    32'h6_0_10_01_10,
    32'h7_0_28_02_20,
    32'h0_0_0A_01_0A,
    32'h5_1_0A_01_0A
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_xfer(input logic [2:0] code, input int cnt, input bit dis, input bit mst);
    @(negedge clk);
    burst_code  = code;
    xfer_count  = CW'(cnt);
    cnt_disable = dis;
    master_mode = mst;
    start       = 1'b1;
    @(negedge clk);
    start       = 1'b0;
  endtask

  task automatic run_until_done(output int bursts, output int maxrun, output int acks);
    int run;
    bit prev;
    bursts = 0; maxrun = 0; acks = 0; run = 0; prev = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (dreq) begin
        run++;
        if (ack_en) acks++;
        if (!prev) bursts++;
        if (run > maxrun) maxrun = run;
      end else begin
        run = 0;
      end
      prev = dreq;
      if (done && !dreq) break;
      @(negedge clk);
    end
  endtask

  task automatic measure_run(output int len);
    len = 0;
    for (int i = 0; i < 200 && !dreq; i++) @(negedge clk);
    for (int i = 0; i < 200 && dreq; i++) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    for (;;) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int b, m, a, len;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dreq == 1'b0, "R1 dreq after reset", dreq, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(remaining == '0, "R1 remaining after reset", remaining, 0);

    // R2 R3 R5 R7 vector walk
    ack_en = 1'b1;
    foreach (VEC[i]) begin
      start_xfer(VEC[i][30:28], int'(VEC[i][23:16]), 1'b0, VEC[i][24]);
      run_until_done(b, m, a);
      check(b == int'(VEC[i][15:8]), $sformatf("R3 bursts vec%0d", i), b, int'(VEC[i][15:8]));
      check(m == int'(VEC[i][7:0]), $sformatf("R2 longest run vec%0d", i), m, int'(VEC[i][7:0]));
      check(a == int'(VEC[i][23:16]), $sformatf("R5 transfers vec%0d", i), a, int'(VEC[i][23:16]));
      check(done && remaining == '0, $sformatf("R5 done vec%0d", i), int'(remaining), 0);
    end

    // R5 zero count finishes at once
    start_xfer(3'd2, 0, 1'b0, 1'b0);
    check(done == 1'b1, "R5 zero count done", done, 1);
    check(dreq == 1'b0, "R5 zero count no request", dreq, 0);

    // R8 grouped resume restarts the group (code 3, group of 4, transmit)
    dir_rx = 1'b0;
    start_xfer(3'd3, 10, 1'b0, 1'b0);
    for (int i = 0; i < 50 && !dreq; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    fifo_empty = 1'b1;
    #1;
    check(dreq == 1'b0, "R8 empty drops request", dreq, 0);
    check(remaining == CW'(8), "R8 count at block", int'(remaining), 8);
    @(negedge clk);
    fifo_empty = 1'b0;
    measure_run(len);
    check(len == 4, "R8 full group after resume", len, 4);
    run_until_done(b, m, a);
    check(done == 1'b1, "R8 finishes after resume", done, 1);

    // R8 receive direction watches full only
    dir_rx = 1'b1;
    start_xfer(3'd0, 20, 1'b0, 1'b0);
    for (int i = 0; i < 50 && !dreq; i++) @(negedge clk);
    fifo_empty = 1'b1;
    #1;
    check(dreq == 1'b1, "R8 empty ignored on receive", dreq, 1);
    fifo_full = 1'b1;
    #1;
    check(dreq == 1'b0, "R8 full drops request on receive", dreq, 0);
    @(negedge clk);
    fifo_full = 1'b0;
    fifo_empty = 1'b0;
    run_until_done(b, m, a);
    check(done == 1'b1, "R8 receive finishes", done, 1);
    dir_rx = 1'b0;

    // R4 not enough FIFO for a group
    fifo_avail = AW'(5);
    start_xfer(3'd4, 20, 1'b0, 1'b0);
    len = 0;
    for (int i = 0; i < 10; i++) begin
      if (dreq) len++;
      @(negedge clk);
    end
    check(len == 0, "R4 no request below group", len, 0);
    fifo_avail = AW'(8);
    @(negedge clk);
    check(dreq == 1'b1, "R4 request once group fits", dreq, 1);
    run_until_done(b, m, a);
    check(done == 1'b1, "R4 grouped finish", done, 1);

    // R4 remainder smaller than group
    fifo_avail = AW'(3);
    start_xfer(3'd4, 3, 1'b0, 1'b0);
    @(negedge clk);
    check(dreq == 1'b1, "R4 short remainder requests", dreq, 1);
    run_until_done(b, m, a);
    check(a == 3, "R4 short remainder transfers", a, 3);
    fifo_avail = AW'(64);

    // R9 changes during a transfer are ignored
    ack_en = 1'b0;
    start_xfer(3'd1, 4, 1'b0, 1'b0);
    start_xfer(3'd7, 100, 1'b1, 1'b0);
    ack_en = 1'b1;
    run_until_done(b, m, a);
    check(b == 4, "R9 pacing kept", b, 4);
    check(a == 4, "R9 count kept", a, 4);

    // R7 master ignores counter disable
    start_xfer(3'd0, 3, 1'b1, 1'b1);
    run_until_done(b, m, a);
    check(a == 3 && done, "R7 master counts", a, 3);

    // R6 slave counter disabled keeps going
    start_xfer(3'd0, 3, 1'b1, 1'b0);
    repeat (12) @(negedge clk);
    check(dreq == 1'b1, "R6 still requesting", dreq, 1);
    check(done == 1'b0, "R6 not done", done, 0);
    check(remaining == CW'(3), "R6 count held", int'(remaining), 3);

    // R1 reset ends it
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(dreq == 1'b0 && done == 1'b0, "R1 reset clears request", dreq, 0);
    check(remaining == '0, "R1 reset clears count", int'(remaining), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule